// File: doc/BRIEF.md
# Steered Tune-Register Loader

This block is a write-only slave on a byte-wide processor bus (address, data byte, write strobe). It holds six 8-bit storage registers that set up two tune-voltage converter sides, coarse and fine. Each side has a 12-bit low-order DAC word and a 12-bit high-order DAC word. Data bytes are not given individual addresses. Software first writes a steering byte to its own address. That byte selects which storage registers the next data bytes will fill, and it also sets the hold/track state of each converter side. Data bytes then all go to one shared address and are routed to the selected registers.

A full retune takes seven bus writes: the steering byte with all six select lines low, then six data bytes. The data bytes fill the coarse low, middle and high registers, then the fine low, middle and high registers, in that order. A third address produces a one-cycle write-back enable pulse for the analog write-back path.

Top module: `tune_load_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all six storage registers, so all four DAC words read 0. It puts both sides in track (both hold outputs low), leaves no register pending and drives the write-back enable low.
- R2: A write to address 0x70 loads the steering byte. From the next cycle, coarse_hold equals the inverse of bit 3 and fine_hold equals the inverse of bit 7, so a 0 bit means hold and a 1 bit means track.
- R3: Steering bits 0, 1 and 2 are active-low selects for the coarse low, middle and high registers. Steering bits 4, 5 and 6 are active-low selects for the fine low, middle and high registers. A write to 0x71 loads its byte into a selected register, and the register is visible on the outputs in the next cycle.
- R4: For each side, the low-order DAC word is {middle[3:0], low[7:0]} and the high-order DAC word is {high[7:0], middle[7:4]}.
- R5: When several selects are low, each write to 0x71 loads only the lowest-numbered selected register that has not yet been loaded (coarse low, middle, high, then fine low, middle, high). That register is then marked done.
- R6: A write to 0x71 with no pending selected register changes nothing. This covers the case after reset and the case after every selected register has been loaded.
- R7: A new write to 0x70 discards all done marks, so registers that were loaded before can be loaded again.
- R8: wb_en is high for exactly the one cycle after each write to address 0x80 and low in every other cycle.
- R9: Bus cycles with wr_en low, and writes to any other address, do not change the storage registers, the hold outputs or the pending state.
- R10: The seven-write sequence (steering byte 0x88, then six data bytes) loads all six registers and leaves both sides in track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| coarse_lo_dac | output | 12 | Coarse side low-order DAC word |
| coarse_hi_dac | output | 12 | Coarse side high-order DAC word |
| fine_lo_dac | output | 12 | Fine side low-order DAC word |
| fine_hi_dac | output | 12 | Fine side high-order DAC word |
| coarse_hold | output | 1 | Coarse side hold select (1 = hold, 0 = track) |
| fine_hold | output | 1 | Fine side hold select (1 = hold, 0 = track) |
| wb_en | output | 1 | One-cycle write-back enable pulse |

## Verification
The properties check these rules on every cycle:
- The write-back pulse follows exactly the writes to 0x80.
- The hold outputs take the inverted steering bits, and change only after a steering write.
- The DAC words stay fixed unless a data write came first.
- A single data write never changes more than one storage byte.

Which byte a data write picks depends on history: the selection order, the done marks, the clearing of those marks on a new steering write, and ignored writes when nothing is pending. Only the bench's reference model and its directed sequences can show that history.

// File: rtl/tlc_pkg.sv
`timescale 1ns/1ps
package tlc_pkg;
   // One decoded bus access; at most one field is set per cycle.
   typedef struct packed {
      logic steer;
      logic data;
      logic wb;
   } tlc_hit_t;

   localparam int unsigned TLC_SIDES     = 2;
   localparam int unsigned TLC_REGS_SIDE = 3;
endpackage

// File: rtl/tlc_bus_decode.sv
`timescale 1ns/1ps
module tlc_bus_decode
   import tlc_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 8,
   parameter logic [ADDR_W-1:0]    STEER_ADDR = 8'h70,
   parameter logic [ADDR_W-1:0]    DATA_ADDR  = 8'h71,
   parameter logic [ADDR_W-1:0]    WB_ADDR    = 8'h80
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output tlc_hit_t          hit
);
   generate
      if ((STEER_ADDR == DATA_ADDR) || (STEER_ADDR == WB_ADDR) || (DATA_ADDR == WB_ADDR)) begin : g_bad_map
         $error("tlc_bus_decode: the three addresses must differ");
      end
   endgenerate

   always_comb begin
      hit.steer = wr_en && (wr_addr == STEER_ADDR);
      hit.data  = wr_en && (wr_addr == DATA_ADDR);
      hit.wb    = wr_en && (wr_addr == WB_ADDR);
   end
endmodule

// File: rtl/tlc_steer_ctrl.sv
`timescale 1ns/1ps
module tlc_steer_ctrl #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_SIDE  = 2,
   parameter int unsigned REGS_SIDE = 3,
   localparam int unsigned SIDE_W   = REGS_SIDE + 1,
   localparam int unsigned NUM_REG  = NUM_SIDE * REGS_SIDE
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                hit_steer,
   input  logic                hit_data,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [NUM_REG-1:0]  load,
   output logic [NUM_SIDE-1:0] hold
);
   generate
      if (NUM_SIDE * SIDE_W != DATA_W) begin : g_bad_layout
         $error("tlc_steer_ctrl: steering byte must hold REGS_SIDE selects plus one hold bit per side");
      end
   endgenerate

   logic [NUM_REG-1:0]  pend_q;
   logic [NUM_REG-1:0]  sel_new;
   logic [NUM_REG-1:0]  pick;
   logic [NUM_SIDE-1:0] track_new;
   logic [NUM_SIDE-1:0] track_q;

   // Unpack active-low select lines and the track bit of every side.
   for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
      for (genvar k = 0; k < REGS_SIDE; k++) begin : g_line
         assign sel_new[s*REGS_SIDE + k] = ~wr_data[s*SIDE_W + k];
      end
      assign track_new[s] = wr_data[s*SIDE_W + REGS_SIDE];
      assign hold[s]      = ~track_q[s];
   end

   // Lowest-numbered pending register wins.
   always_comb begin
      logic seen;
      pick = '0;
      seen = 1'b0;
      for (int i = 0; i < NUM_REG; i++) begin
         if (pend_q[i] && !seen) begin
            pick[i] = 1'b1;
         end
         seen = seen | pend_q[i];
      end
   end

   assign load = hit_data ? pick : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= '0;
         track_q <= '1;
      end else if (hit_steer) begin
         pend_q  <= sel_new;
         track_q <= track_new;
      end else if (hit_data) begin
         pend_q  <= pend_q & ~pick;
      end
   end
endmodule

// File: rtl/tlc_store_bank.sv
`timescale 1ns/1ps
module tlc_store_bank #(
   parameter int unsigned NUM_REG = 6,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned FLAT_W = NUM_REG * DATA_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_REG-1:0] load,
   input  logic [DATA_W-1:0]  din,
   output logic [FLAT_W-1:0]  q_flat
);
   generate
      if (NUM_REG == 0) begin : g_bad_depth
         $error("tlc_store_bank: NUM_REG must be nonzero");
      end
   endgenerate

   for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (load[r]) begin
            q <= din;
         end
      end
      assign q_flat[r*DATA_W +: DATA_W] = q;
   end
endmodule

// File: rtl/tlc_dac_map.sv
`timescale 1ns/1ps
module tlc_dac_map #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_SIDE = 2,
   parameter int unsigned DAC_W    = 12,
   localparam int unsigned HALF    = DATA_W / 2,
   localparam int unsigned REGS_SIDE = 3,
   localparam int unsigned NUM_REG = NUM_SIDE * REGS_SIDE
) (
   input  logic [NUM_REG*DATA_W-1:0]  reg_flat,
   output logic [NUM_SIDE*DAC_W-1:0]  lo_flat,
   output logic [NUM_SIDE*DAC_W-1:0]  hi_flat
);
   generate
      if ((DATA_W % 2 != 0) || (DAC_W != DATA_W + HALF)) begin : g_bad_width
         $error("tlc_dac_map: DAC_W must be one and a half storage bytes");
      end
   endgenerate

   for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
      logic [DATA_W-1:0] lo_b;
      logic [DATA_W-1:0] mid_b;
      logic [DATA_W-1:0] hi_b;
      assign lo_b  = reg_flat[(s*REGS_SIDE + 0)*DATA_W +: DATA_W];
      assign mid_b = reg_flat[(s*REGS_SIDE + 1)*DATA_W +: DATA_W];
      assign hi_b  = reg_flat[(s*REGS_SIDE + 2)*DATA_W +: DATA_W];
      assign lo_flat[s*DAC_W +: DAC_W] = {mid_b[HALF-1:0], lo_b};
      assign hi_flat[s*DAC_W +: DAC_W] = {hi_b, mid_b[DATA_W-1:HALF]};
   end
endmodule

// File: rtl/tune_load_ctrl.sv
`timescale 1ns/1ps
module tune_load_ctrl
   import tlc_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       DAC_W      = 12,
   parameter logic [ADDR_W-1:0] STEER_ADDR = 8'h70,
   parameter logic [ADDR_W-1:0] DATA_ADDR  = 8'h71,
   parameter logic [ADDR_W-1:0] WB_ADDR    = 8'h80
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DAC_W-1:0]  coarse_lo_dac,
   output logic [DAC_W-1:0]  coarse_hi_dac,
   output logic [DAC_W-1:0]  fine_lo_dac,
   output logic [DAC_W-1:0]  fine_hi_dac,
   output logic              coarse_hold,
   output logic              fine_hold,
   output logic              wb_en
);
   localparam int unsigned NUM_SIDE  = TLC_SIDES;
   localparam int unsigned REGS_SIDE = TLC_REGS_SIDE;
   localparam int unsigned NUM_REG   = NUM_SIDE * REGS_SIDE;

   generate
      if (NUM_SIDE != 2) begin : g_bad_sides
         $error("tune_load_ctrl: ports expose exactly a coarse and a fine side");
      end
   endgenerate

   tlc_hit_t                    hit;
   logic [NUM_REG-1:0]          load;
   logic [NUM_SIDE-1:0]         hold;
   logic [NUM_REG*DATA_W-1:0]   reg_flat;
   logic [NUM_SIDE*DAC_W-1:0]   lo_flat;
   logic [NUM_SIDE*DAC_W-1:0]   hi_flat;
   logic                        wb_q;

   tlc_bus_decode #(
      .ADDR_W(ADDR_W), .STEER_ADDR(STEER_ADDR),
      .DATA_ADDR(DATA_ADDR), .WB_ADDR(WB_ADDR)
   ) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
   );

   tlc_steer_ctrl #(
      .DATA_W(DATA_W), .NUM_SIDE(NUM_SIDE), .REGS_SIDE(REGS_SIDE)
   ) u_steer (
      .clk(clk), .rst(rst), .hit_steer(hit.steer), .hit_data(hit.data),
      .wr_data(wr_data), .load(load), .hold(hold)
   );

   tlc_store_bank #(
      .NUM_REG(NUM_REG), .DATA_W(DATA_W)
   ) u_bank (
      .clk(clk), .rst(rst), .load(load), .din(wr_data), .q_flat(reg_flat)
   );

   tlc_dac_map #(
      .DATA_W(DATA_W), .NUM_SIDE(NUM_SIDE), .DAC_W(DAC_W)
   ) u_map (
      .reg_flat(reg_flat), .lo_flat(lo_flat), .hi_flat(hi_flat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wb_q <= 1'b0;
      end else begin
         wb_q <= hit.wb;
      end
   end

   assign coarse_lo_dac = lo_flat[0 +: DAC_W];
   assign coarse_hi_dac = hi_flat[0 +: DAC_W];
   assign fine_lo_dac   = lo_flat[DAC_W +: DAC_W];
   assign fine_hi_dac   = hi_flat[DAC_W +: DAC_W];
   assign coarse_hold   = hold[0];
   assign fine_hold     = hold[1];
   assign wb_en         = wb_q;
endmodule

// File: rtl/tlc_chk.sv
`timescale 1ns/1ps
module tlc_chk #(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       DAC_W      = 12,
   parameter logic [ADDR_W-1:0] STEER_ADDR = 8'h70,
   parameter logic [ADDR_W-1:0] DATA_ADDR  = 8'h71,
   parameter logic [ADDR_W-1:0] WB_ADDR    = 8'h80,
   localparam int unsigned      HALF       = DAC_W / 3
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [1:0]        track_bits,
   input logic [DAC_W-1:0]  coarse_lo_dac,
   input logic [DAC_W-1:0]  coarse_hi_dac,
   input logic [DAC_W-1:0]  fine_lo_dac,
   input logic [DAC_W-1:0]  fine_hi_dac,
   input logic              coarse_hold,
   input logic              fine_hold,
   input logic              wb_en
);
   logic [4*DAC_W-1:0] dacs;
   logic [4*DAC_W-1:0] dacs_prev;
   logic [5:0]         chg;

   assign dacs = {fine_hi_dac, fine_lo_dac, coarse_hi_dac, coarse_lo_dac};

   always_ff @(posedge clk) begin
      dacs_prev <= dacs;
   end

   // Which of the six storage bytes moved since the previous cycle.
   always_comb begin
      chg[0] = coarse_lo_dac[2*HALF-1:0] != dacs_prev[2*HALF-1:0];
      chg[1] = ({coarse_lo_dac[DAC_W-1:2*HALF], coarse_hi_dac[HALF-1:0]}
                != {dacs_prev[DAC_W-1:2*HALF], dacs_prev[DAC_W +: HALF]});
      chg[2] = coarse_hi_dac[DAC_W-1:HALF] != dacs_prev[DAC_W+HALF +: 2*HALF];
      chg[3] = fine_lo_dac[2*HALF-1:0] != dacs_prev[2*DAC_W +: 2*HALF];
      chg[4] = ({fine_lo_dac[DAC_W-1:2*HALF], fine_hi_dac[HALF-1:0]}
                != {dacs_prev[2*DAC_W+2*HALF +: HALF], dacs_prev[3*DAC_W +: HALF]});
      chg[5] = fine_hi_dac[DAC_W-1:HALF] != dacs_prev[3*DAC_W+HALF +: 2*HALF];
   end

   AST_WB_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == WB_ADDR) |=> wb_en); // R8
   AST_WB_QUIET: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == WB_ADDR) |=> !wb_en); // R8
   AST_HOLD_TAKES_STEER: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == STEER_ADDR) |=>
      (coarse_hold == !$past(track_bits[0]) && fine_hold == !$past(track_bits[1]))); // R2
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == STEER_ADDR) |=> $stable({coarse_hold, fine_hold})); // R9
   AST_DAC_STABLE: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == DATA_ADDR) |=> $stable(dacs)); // R9
   AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == DATA_ADDR) |=> ($countones(chg) <= 1)); // R5
endmodule

bind tune_load_ctrl tlc_chk #(
   .ADDR_W(ADDR_W), .DAC_W(DAC_W), .STEER_ADDR(STEER_ADDR),
   .DATA_ADDR(DATA_ADDR), .WB_ADDR(WB_ADDR)
) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
   .track_bits({wr_data[7], wr_data[3]}),
   .coarse_lo_dac(coarse_lo_dac), .coarse_hi_dac(coarse_hi_dac),
   .fine_lo_dac(fine_lo_dac), .fine_hi_dac(fine_hi_dac),
   .coarse_hold(coarse_hold), .fine_hold(fine_hold), .wb_en(wb_en)
);

// File: tb/tune_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module tune_load_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = 8'h00;
   logic [7:0]  wr_data = 8'h00;
   logic [11:0] coarse_lo_dac, coarse_hi_dac, fine_lo_dac, fine_hi_dac;
   logic        coarse_hold, fine_hold, wb_en;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   tune_load_ctrl dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .coarse_lo_dac(coarse_lo_dac), .coarse_hi_dac(coarse_hi_dac),
      .fine_lo_dac(fine_lo_dac), .fine_hi_dac(fine_hi_dac),
      .coarse_hold(coarse_hold), .fine_hold(fine_hold), .wb_en(wb_en)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_reg [6];
   logic       m_hold_c = 1'b0;
   logic       m_hold_f = 1'b0;
   logic       m_wb = 1'b0;
   int         m_pend [$];

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 6; i++) m_reg[i] = 8'h00;
         m_pend.delete();
         m_hold_c = 1'b0;
         m_hold_f = 1'b0;
         m_wb = 1'b0;
      end else begin
         m_wb = wr_en && (wr_addr == 8'h80);
         if (wr_en && wr_addr == 8'h70) begin
            m_pend.delete();
            for (int i = 0; i < 6; i++) begin
               if (!wr_data[(i / 3) * 4 + (i % 3)]) m_pend.push_back(i);
            end
            m_hold_c = !wr_data[3];
            m_hold_f = !wr_data[7];
         end else if (wr_en && wr_addr == 8'h71 && m_pend.size() > 0) begin
            int t;
            t = m_pend.pop_front();
            m_reg[t] = wr_data;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (!rst && !finished) begin
         chk("R4", "coarse_lo", {20'h0, coarse_lo_dac}, {20'h0, m_reg[1][3:0], m_reg[0]});
         chk("R4", "coarse_hi", {20'h0, coarse_hi_dac}, {20'h0, m_reg[2], m_reg[1][7:4]});
         chk("R4", "fine_lo",   {20'h0, fine_lo_dac},   {20'h0, m_reg[4][3:0], m_reg[3]});
         chk("R4", "fine_hi",   {20'h0, fine_hi_dac},   {20'h0, m_reg[5], m_reg[4][7:4]});
         chk("R2", "holds", {30'h0, coarse_hold, fine_hold}, {30'h0, m_hold_c, m_hold_f});
         chk("R8", "wb_en", {31'h0, wb_en}, {31'h0, m_wb});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      idle(3);
      rst = 1'b0;
      // R1: reset state
      chk("R1", "coarse_lo", {20'h0, coarse_lo_dac}, 32'h0);
      chk("R1", "fine_hi", {20'h0, fine_hi_dac}, 32'h0);
      chk("R1", "holds", {30'h0, coarse_hold, fine_hold}, 32'h0);
      chk("R1", "wb_en", {31'h0, wb_en}, 32'h0);
      // R6: data write with nothing pending after reset
      bus_wr(8'h71, 8'hAA);
      chk("R6", "coarse_lo", {20'h0, coarse_lo_dac}, 32'h0);
      // R2: hold bits
      bus_wr(8'h70, 8'hF7);
      chk("R2", "coarse hold", {31'h0, coarse_hold}, 32'h1);
      chk("R2", "fine hold", {31'h0, fine_hold}, 32'h0);
      bus_wr(8'h70, 8'h7F);
      chk("R2", "coarse hold", {31'h0, coarse_hold}, 32'h0);
      chk("R2", "fine hold", {31'h0, fine_hold}, 32'h1);
      // R3: single select on coarse middle
      bus_wr(8'h70, 8'hFD);
      bus_wr(8'h71, 8'h5C);
      chk("R3", "coarse_lo", {20'h0, coarse_lo_dac}, 32'hC00);
      chk("R3", "coarse_hi", {20'h0, coarse_hi_dac}, 32'h005);
      // R10 and R5: full seven-write update
      bus_wr(8'h70, 8'h88);
      bus_wr(8'h71, 8'h11);
      chk("R5", "coarse_lo first", {20'h0, coarse_lo_dac}, 32'hC11);
      chk("R5", "fine_lo untouched", {20'h0, fine_lo_dac}, 32'h000);
      bus_wr(8'h71, 8'h22);
      bus_wr(8'h71, 8'h33);
      bus_wr(8'h71, 8'h44);
      bus_wr(8'h71, 8'h55);
      bus_wr(8'h71, 8'h66);
      chk("R10", "coarse_lo", {20'h0, coarse_lo_dac}, 32'h211);
      chk("R10", "coarse_hi", {20'h0, coarse_hi_dac}, 32'h332);
      chk("R10", "fine_lo", {20'h0, fine_lo_dac}, 32'h544);
      chk("R10", "fine_hi", {20'h0, fine_hi_dac}, 32'h665);
      chk("R10", "holds", {30'h0, coarse_hold, fine_hold}, 32'h0);
      // R6: extra write once all are done
      bus_wr(8'h71, 8'h99);
      chk("R6", "coarse_lo", {20'h0, coarse_lo_dac}, 32'h211);
      chk("R6", "fine_hi", {20'h0, fine_hi_dac}, 32'h665);
      // R7: re-steering clears done marks
      bus_wr(8'h70, 8'hBB);
      bus_wr(8'h71, 8'h7E);
      chk("R7", "coarse_hi first", {20'h0, coarse_hi_dac}, 32'h7E2);
      bus_wr(8'h70, 8'hBB);
      bus_wr(8'h71, 8'h3C);
      chk("R7", "coarse_hi again", {20'h0, coarse_hi_dac}, 32'h3C2);
      chk("R7", "fine_hi kept", {20'h0, fine_hi_dac}, 32'h665);
      // R9: strobe low and foreign address have no effect
      wr_en = 1'b0; wr_addr = 8'h71; wr_data = 8'hEE;
      idle(1);
      wr_addr = 8'h70; wr_data = 8'h00;
      idle(1);
      chk("R9", "fine_hi", {20'h0, fine_hi_dac}, 32'h665);
      chk("R9", "holds", {30'h0, coarse_hold, fine_hold}, 32'h0);
      bus_wr(8'h72, 8'hEE);
      chk("R9", "fine_hi", {20'h0, fine_hi_dac}, 32'h665);
      bus_wr(8'h71, 8'h0F);
      chk("R9", "pending kept, fine_hi", {20'h0, fine_hi_dac}, 32'h0F5);
      // R8: write-back pulse
      chk("R8", "wb idle", {31'h0, wb_en}, 32'h0);
      bus_wr(8'h80, 8'h00);
      chk("R8", "wb pulse", {31'h0, wb_en}, 32'h1);
      idle(1);
      chk("R8", "wb ends", {31'h0, wb_en}, 32'h0);
      bus_wr(8'h80, 8'h00);
      bus_wr(8'h80, 8'h00);
      chk("R8", "wb second", {31'h0, wb_en}, 32'h1);
      idle(1);
      // R1: reset in mid-run
      bus_wr(8'h70, 8'h00);
      rst = 1'b1;
      idle(1);
      rst = 1'b0;
      chk("R1", "coarse_hi", {20'h0, coarse_hi_dac}, 32'h0);
      chk("R1", "holds", {30'h0, coarse_hold, fine_hold}, 32'h0);
      bus_wr(8'h71, 8'h5A);
      chk("R1", "no pending after reset", {20'h0, coarse_lo_dac}, 32'h0);
      idle(2);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule